// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block turns one IEEE-754 single-precision value into a two's-complement signed integer. The integer is 32 bits wide by default. It is 64 bits wide when the caller is in 64-bit mode and also asks for a wide result. The conversion is computed combinationally. A result register captures it on the cycle in which the input strobe is high, and an output-valid pulse marks the cycle in which the registered result is fresh.

The rounding mode is chosen for each operation. A per-operation override applies only when the operand comes from a register and the override enable is set. In every other case the global rounding field is used. When a value cannot be represented, the block returns a fixed indefinite integer and raises an invalid flag. When a value can be represented but is not exact, it is rounded and an inexact flag is raised. Traps are assumed masked.

Top module: `f32_int_convert`

## Requirements
- R1: Only bits [31:0] of `src_word` are converted; bits [63:32] have no effect on any output.
- R2: The destination is 64 bits only when `long_mode` and `wide_req` are both 1; otherwise it is 32 bits, the value sits sign-extended to 32 bits in `result[31:0]` and `result[63:32]` is zero.
- R3: The effective rounding field is `emb_rnd` when `src_is_reg` and `emb_rnd_en` are both 1, and `glb_rnd` otherwise.
- R4: Rounding-field encoding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, 2'b11 truncates toward zero.
- R5: The range check is applied to the rounded value. If it lies outside [-2^(W-1), 2^(W-1)-1], `invalid` is 1 and `result` is the indefinite value: 64'h0000_0000_8000_0000 for W=32 and 64'h8000_0000_0000_0000 for W=64.
- R6: An exponent field of all ones (NaN of either kind, or ±infinity) gives the indefinite value with `invalid`=1 and `inexact`=0.
- R7: Both zeros give 0 with no flags. Subnormals are converted by their true value, so they round to 0, -1 or +1 according to the mode and the sign, with `inexact`=1.
- R8: `inexact` is 1 exactly when a representable result differs from the input value. It is never 1 together with `invalid`.
- R9: `out_valid` is 1 in the cycle after `in_valid` was sampled 1, and 0 otherwise. `result` and both flags hold their values while no strobe arrives. Reset clears `out_valid`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: convert the present inputs |
| src_word | input | 64 | Source operand; the float sits in bits [31:0] |
| wide_req | input | 1 | Request for a 64-bit destination |
| long_mode | input | 1 | 64-bit mode is active |
| glb_rnd | input | 2 | Global rounding field |
| emb_rnd_en | input | 1 | Enable for the per-operation rounding override |
| emb_rnd | input | 2 | Per-operation rounding field |
| src_is_reg | input | 1 | Operand comes from a register rather than memory |
| out_valid | output | 1 | Registered result is fresh this cycle |
| result | output | 64 | Converted integer or indefinite value |
| invalid | output | 1 | Unrepresentable input or result |
| inexact | output | 1 | Result was rounded |

## Verification
Several properties are checked on every cycle. These are the one-cycle strobe-to-valid timing, the holding of the outputs between strobes, the zero upper half in narrow mode, the indefinite pattern that goes with each invalid result, the invalid-only response to NaN and infinity, the flag-free conversion of zeros, and the rule that the two flags never appear together. The numeric results cannot be checked that way. These are the rounding direction in each mode, tie breaking, the range limits after rounding at ±2^31 and ±2^63, the choice between the override and the global field, and the neutrality of the upper source bits. The bench scenarios show them by sweeping every exponent, several mantissa patterns, both signs, all four modes and all width configurations against an arithmetic model.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int BIAS   = 127;
    localparam int SIG_W  = MAN_W + 1;
    // exponent at which the significand LSB has weight one
    localparam int UNIT_E = BIAS + MAN_W;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_DOWN      = 2'b01,
        RND_UP        = 2'b10,
        RND_ZERO      = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic        valid;
        logic [63:0] result;
        logic        invalid;
        logic        inexact;
    } conv_state_s;
endpackage

// File: rtl/f2i_round_sel.sv
module f2i_round_sel
    import f2i_pkg::*;
(
    input  logic       src_is_reg,
    input  logic       emb_rnd_en,
    input  logic [1:0] emb_rnd,
    input  logic [1:0] glb_rnd,
    output rnd_mode_e  mode
);
    always_comb begin
        if (src_is_reg && emb_rnd_en) mode = rnd_mode_e'(emb_rnd);
        else                          mode = rnd_mode_e'(glb_rnd);
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
#(
    parameter int MAG_W = 65
) (
    input  logic [FP_W-1:0]  fp,
    output logic             sign,
    output logic             special,
    output logic             huge,
    output logic [MAG_W-1:0] mag,
    output logic             guard,
    output logic             sticky
);
    localparam int MAX_LSH = MAG_W - 1 - SIG_W;
    localparam int MAX_RSH = SIG_W + 1;
    localparam int T_W     = 2 * SIG_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig;
    logic [T_W-1:0]   tmp;
    int               eff_e;
    int               sh;

    always_comb begin
        exp_f   = fp[FP_W-2 -: EXP_W];
        sign    = fp[FP_W-1];
        special = &exp_f;
        sig     = {|exp_f, fp[MAN_W-1:0]};
        eff_e   = (exp_f == '0) ? 1 : int'(exp_f);
        mag     = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        huge    = 1'b0;
        tmp     = '0;
        sh      = 0;
        if (eff_e >= UNIT_E) begin
            sh = eff_e - UNIT_E;
            if (sh > MAX_LSH) huge = 1'b1;
            else              mag  = MAG_W'(sig) << sh;
        end else begin
            sh = UNIT_E - eff_e;
            if (sh > MAX_RSH) begin
                sticky = |sig;
            end else begin
                tmp    = {sig, (SIG_W + 1)'(0)} >> sh;
                mag    = MAG_W'(tmp[T_W-1 -: SIG_W]);
                guard  = tmp[SIG_W];
                sticky = |tmp[SIG_W-1:0];
            end
        end
    end
endmodule

// File: rtl/f2i_round_pack.sv
module f2i_round_pack
    import f2i_pkg::*;
#(
    parameter int MAG_W    = 65,
    parameter int RES_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             sign,
    input  logic             special,
    input  logic             huge,
    input  logic [MAG_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    input  rnd_mode_e        mode,
    input  logic             wide,
    output logic [RES_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam logic [MAG_W-1:0] POS_W = (MAG_W'(1) << (RES_W - 1)) - 1'b1;
    localparam logic [MAG_W-1:0] POS_N = (MAG_W'(1) << (NARROW_W - 1)) - 1'b1;
    localparam logic [RES_W-1:0] IND_W = RES_W'(1) << (RES_W - 1);
    localparam logic [RES_W-1:0] IND_N = RES_W'(1) << (NARROW_W - 1);

    logic             lost;
    logic             inc;
    logic [MAG_W-1:0] mag_r;
    logic [MAG_W-1:0] limit;
    logic [RES_W-1:0] sval;
    logic             ovf;

    always_comb begin
        lost = guard | sticky;
        unique case (mode)
            RND_NEAR_EVEN: inc = guard & (sticky | mag[0]);
            RND_DOWN:      inc = sign & lost;
            RND_UP:        inc = ~sign & lost;
            default:       inc = 1'b0;
        endcase
        mag_r   = mag + MAG_W'(inc);
        limit   = (wide ? POS_W : POS_N) + MAG_W'(sign);
        ovf     = huge | (mag_r > limit);
        invalid = special | ovf;
        inexact = ~invalid & lost;
        sval    = sign ? (~mag_r[RES_W-1:0] + 1'b1) : mag_r[RES_W-1:0];
        if (invalid)   result = wide ? IND_W : IND_N;
        else if (wide) result = sval;
        else           result = {(RES_W - NARROW_W)'(0), sval[NARROW_W-1:0]};
    end
endmodule

// File: rtl/f32_int_convert.sv
module f32_int_convert
    import f2i_pkg::*;
#(
    parameter int SRC_W    = 64,
    parameter int RES_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src_word,
    input  logic             wide_req,
    input  logic             long_mode,
    input  logic [1:0]       glb_rnd,
    input  logic             emb_rnd_en,
    input  logic [1:0]       emb_rnd,
    input  logic             src_is_reg,
    output logic             out_valid,
    output logic [RES_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam int MAG_W = RES_W + 1;

    rnd_mode_e        mode;
    logic             sign, special, huge, guard, sticky, wide;
    logic [MAG_W-1:0] mag;
    logic [RES_W-1:0] conv_res;
    logic             conv_inv, conv_inx;
    conv_state_s      st_d, st_q;

    assign wide = long_mode & wide_req;

    f2i_round_sel i_sel (
        .src_is_reg (src_is_reg),
        .emb_rnd_en (emb_rnd_en),
        .emb_rnd    (emb_rnd),
        .glb_rnd    (glb_rnd),
        .mode       (mode)
    );

    f2i_align #(.MAG_W(MAG_W)) i_align (
        .fp      (src_word[FP_W-1:0]),
        .sign    (sign),
        .special (special),
        .huge    (huge),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky)
    );

    f2i_round_pack #(.MAG_W(MAG_W), .RES_W(RES_W), .NARROW_W(NARROW_W)) i_pack (
        .sign    (sign),
        .special (special),
        .huge    (huge),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .mode    (mode),
        .wide    (wide),
        .result  (conv_res),
        .invalid (conv_inv),
        .inexact (conv_inx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = conv_res;
            st_d.invalid = conv_inv;
            st_d.inexact = conv_inx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign invalid   = st_q.invalid;
    assign inexact   = st_q.inexact;
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker #(
    parameter int SRC_W = 64,
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SRC_W-1:0] src_word,
    input logic             wide_req,
    input logic             long_mode,
    input logic             out_valid,
    input logic [RES_W-1:0] result,
    input logic             invalid,
    input logic             inexact
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(invalid) && $stable(inexact)));

    assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(long_mode && wide_req)) |-> (result[63:32] == 32'h0));

    assert_indefinite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |->
            (result == ($past(long_mode && wide_req) ? 64'h8000_0000_0000_0000
                                                     : 64'h0000_0000_8000_0000)));

    assert_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&src_word[30:23])) |=> (invalid && !inexact));

    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_word[30:0] == 31'h0)) |=> (result == '0 && !invalid && !inexact));

    assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> !inexact);
endmodule

bind f32_int_convert f2i_checker #(.SRC_W(SRC_W), .RES_W(RES_W)) i_chk (.*);

// File: tb/test_f32_int_convert.sv
module test_f32_int_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_word = '0;
    logic        wide_req = 1'b0;
    logic        long_mode = 1'b0;
    logic [1:0]  glb_rnd = 2'b00;
    logic        emb_rnd_en = 1'b0;
    logic [1:0]  emb_rnd = 2'b00;
    logic        src_is_reg = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;
    logic        inexact;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [31:0] upper = 32'h1234_5679;

    always #4 clk = ~clk;

    f32_int_convert i_f32_int_convert (.*);

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_bad++;
                $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    // arithmetic model of the conversion
    function automatic void model(input logic [31:0] w, input logic wd, input logic [1:0] md,
                                  output logic [63:0] r, output logic inv, output logic inx);
        real v, fl, fr, rr, lim;
        longint li;
        int e;
        e = int'(w[30:23]);
        inv = 1'b0; inx = 1'b0;
        if (e == 255) begin
            inv = 1'b1;
        end else begin
            if (e == 0) v = real'(w[22:0]) * (2.0 ** (-149.0));
            else        v = (real'(w[22:0]) + 8388608.0) * (2.0 ** (real'(e) - 150.0));
            if (w[31]) v = -v;
            fl = $floor(v);
            fr = v - fl;
            case (md)
                2'b00: begin
                    if (fr > 0.5)      rr = fl + 1.0;
                    else if (fr < 0.5) rr = fl;
                    else               rr = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
                end
                2'b01:   rr = fl;
                2'b10:   rr = $ceil(v);
                default: rr = (v < 0.0) ? $ceil(v) : fl;
            endcase
            lim = wd ? 2.0 ** 63.0 : 2.0 ** 31.0;
            if (rr >= lim || rr < -lim) inv = 1'b1;
            else begin
                li  = longint'(rr);
                r   = wd ? 64'(li) : {32'h0, li[31:0]};
                inx = (rr != v);
            end
        end
        if (inv) r = wd ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    endfunction

    task automatic apply(input logic [31:0] w, input logic wr, input logic lm,
                         input logic [1:0] g, input logic en, input logic [1:0] em,
                         input logic isreg, input string tag);
        logic [63:0] er;
        logic ei, ex;
        logic [1:0] md;
        md = (isreg && en) ? em : g;
        model(w, wr && lm, md, er, ei, ex);
        upper = {upper[30:0], upper[31] ^ upper[21] ^ upper[1] ^ upper[0]};
        src_word = {upper, w};
        wide_req = wr; long_mode = lm; glb_rnd = g;
        emb_rnd_en = en; emb_rnd = em; src_is_reg = isreg;
        in_valid = 1'b1;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b1 || result !== er || invalid !== ei || inexact !== ex) begin
            n_bad++;
            $display("FAIL %s: src=%h mode=%0d wide=%0b got v=%b r=%h i=%b x=%b expected v=1 r=%h i=%b x=%b",
                     tag, w, md, wr && lm, out_valid, result, invalid, inexact, er, ei, ex);
        end
    endtask

    task automatic check_hold();
        logic [63:0] r0;
        logic i0, x0;
        r0 = result; i0 = invalid; x0 = inexact;
        in_valid = 1'b0;
        src_word = 64'h0000_0000_7F80_0000;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || result !== r0 || invalid !== i0 || inexact !== x0) begin
            n_bad++;
            $display("FAIL R9 hold: got v=%b r=%h i=%b x=%b expected v=0 r=%h i=%b x=%b",
                     out_valid, result, invalid, inexact, r0, i0, x0);
        end
    endtask

    function automatic string tag_of(input logic [31:0] w);
        if (&w[30:23])           return "R6";
        else if (w[30:23] == 0)  return "R7";
        else if (w[30:23] > 157) return "R5";
        else                     return "R4";
    endfunction

    logic [31:0] specials [12] = '{32'h4F00_0000, 32'hCF00_0000, 32'h4EFF_FFFF, 32'hCF00_0001,
                                   32'h5F00_0000, 32'hDF00_0000, 32'h3F00_0000, 32'hBF00_0000,
                                   32'h3FC0_0000, 32'h4020_0000, 32'hC020_0000, 32'h7FC0_0001};
    logic [22:0] mants [6] = '{23'h0, 23'h1, 23'h40_0000, 23'h7F_FFFF, 23'h3F_FFFF, 23'h15_5AA5};

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || result !== '0 || invalid !== 1'b0 || inexact !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: got v=%b r=%h i=%b x=%b expected all zero",
                     out_valid, result, invalid, inexact);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: upper source bits vary on every vector; repeat one value several times
        for (int k = 0; k < 8; k++) apply(32'h4049_0FDB, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, "R1");

        // R2 / R5: width selection and the limits around it
        for (int k = 0; k < 12; k++) begin
            for (int c = 0; c < 4; c++)
                apply(specials[k], c[0], c[1], 2'(k % 4), 1'b0, 2'b00, 1'b0,
                      (k < 6) ? "R2" : "R5");
        end

        // R3: choice between override and global field
        for (int g = 0; g < 4; g++)
            for (int em = 0; em < 4; em++)
                for (int sel = 0; sel < 4; sel++) begin
                    apply(32'h4020_0000, 1'b0, 1'b0, 2'(g), sel[0], 2'(em), sel[1], "R3");
                    apply(32'hBFC0_0000, 1'b0, 1'b0, 2'(g), sel[0], 2'(em), sel[1], "R3");
                    apply(32'h3F40_0000, 1'b1, 1'b1, 2'(g), sel[0], 2'(em), sel[1], "R3");
                end

        check_hold();

        // sweep: all exponents, several mantissas, both signs, all modes and widths
        for (int c = 0; c < 4; c++)
            for (int md = 0; md < 4; md++)
                for (int e = 0; e < 256; e++)
                    for (int m = 0; m < 6; m++)
                        for (int s = 0; s < 2; s++) begin
                            logic [31:0] w;
                            w = {s[0], 8'(e), mants[m]};
                            apply(w, c[0], c[1], 2'(md), 1'b1, 2'(3 - md), 1'b0, tag_of(w));
                        end

        // R8: inexact on a rounded value, clear on an exact one
        apply(32'h3FA0_0000, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0, "R8");
        apply(32'h4080_0000, 1'b0, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0, "R8");
        check_hold();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule